// File: doc/BRIEF.md
# Calendar Update Engine

This block holds a ten-byte store of time, calendar and alarm values and advances it by one second every time it receives a one-second tick. The update carries through seconds, minutes, hours, date and day of week, month and year of century. The arithmetic follows the selected number format, binary or BCD, and the selected hour format, 12-hour or 24-hour. When the update is complete, the block compares the new time with three alarm bytes and signals a match. It can also apply the spring-forward and fall-back daylight-saving steps.

A register port gives the host write access and combinational read access to the store. A hold input freezes the time so the host can load it without an update cutting across the writes. A busy output is high while an update is being carried out. A one-cycle pulse marks the end of every completed update, and a second one-cycle pulse marks an alarm match.

Top module: `cal_update_engine`

## Requirements
- R1: Each accepted tick adds one second. A seconds value of 59 becomes 00 and adds one minute, and a minutes value of 59 becomes 00 and adds one hour.
- R2: With `bin_mode`=1 every byte is counted in plain binary, so seconds go from 0x09 to 0x0A. With `bin_mode`=0 every byte is counted in BCD, so seconds go from 0x09 to 0x10.
- R3: With `hr24_mode`=1 the hour byte runs from 0 to 23. Going from 23 to 00 advances the date.
- R4: With `hr24_mode`=0 the hour byte holds 1 to 12 in bits 6:0, and bit 7 is set for PM. 11 AM becomes 12 PM (BCD 0x11 to 0x92), 12 PM becomes 1 PM (0x92 to 0x81), and 12 AM becomes 1 AM. 11 PM becomes 12 AM (0x91 to 0x12) and advances the date.
- R5: The date wraps to 1 after the last day of the month. April, June, September and November have 30 days, February has 28 days, or 29 days when the year value is divisible by 4, and the other months have 31 days. Month 12 wraps to month 1 and advances the year. Year 99 wraps to 00.
- R6: The day of week runs from 1 to 7, with 1 for Sunday. It advances with the date, and 7 wraps to 1.
- R7: `alarm_pulse` goes high, in the same cycle as `done_pulse`, when all three alarm bytes match the updated time. An alarm byte whose bits 7:6 are both 1 matches any value.
- R8: With `dst_en`=1, the hour goes from 01 straight to 03 (1:59:59 AM becomes 3:00:00 AM) when the date is a Sunday (day of week 1) on day 24 or later of April (month 4).
- R9: With `dst_en`=1, on a Sunday on day 25 or later of October (month 10), 1:59:59 AM becomes 1:00:00 AM the first time it is reached. The next time the hour passes 1 AM, it advances normally.
- R10: While `set_hold`=1, ticks are ignored and the store keeps its values. Raising `set_hold` during an update ends the update, with no `done_pulse` and no `alarm_pulse`.
- R11: After an accepted tick, `busy` stays high for exactly 7 cycles. `done_pulse` is high for one cycle, in the first cycle that `busy` is low. A tick that arrives while `busy` is high is ignored.
- R12: The store is addressed as follows: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year, 7 alarm seconds, 8 alarm minutes, 9 alarm hours. A write places the byte at `wr_addr`, and `rd_data` shows the byte at `rd_addr`. Reset clears the store, `busy` and both pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-second advance request |
| bin_mode | input | 1 | 1 selects binary counting, 0 selects BCD |
| hr24_mode | input | 1 | 1 selects the 24-hour format, 0 the 12-hour format with a PM flag |
| dst_en | input | 1 | Enables the daylight-saving steps |
| set_hold | input | 1 | Blocks updates and aborts an update in progress |
| wr_en | input | 1 | Store write strobe |
| wr_addr | input | ADDR_W | Store write address |
| wr_data | input | DATA_W | Store write byte |
| rd_addr | input | ADDR_W | Store read address |
| rd_data | output | DATA_W | Byte at `rd_addr` |
| alarm_pulse | output | 1 | One-cycle alarm match pulse |
| done_pulse | output | 1 | One-cycle pulse at the end of an update |
| busy | output | 1 | High while an update is in progress |

## Verification
The assertions rely on `tick` and `set_hold` being synchronous to `clk`, and on a `busy` rise coming only from a tick seen while the engine is idle. They also rely on the store holding legal values in the selected formats, with the mode inputs held steady during an update. The stimulus loads only well-formed bytes for the mode in use. It changes the mode inputs and writes the store only while the engine is idle, and it drives every input on the falling clock edge.

// File: rtl/cal_pkg.sv
package cal_pkg;
   typedef logic [7:0] byte_t;

   localparam int NUM_REGS = 10;
   localparam int IDX_SEC  = 0;
   localparam int IDX_MIN  = 1;
   localparam int IDX_HR   = 2;
   localparam int IDX_DOW  = 3;
   localparam int IDX_DATE = 4;
   localparam int IDX_MON  = 5;
   localparam int IDX_YR   = 6;
   localparam int IDX_ASEC = 7;
   localparam int IDX_AMIN = 8;
   localparam int IDX_AHR  = 9;

   typedef enum logic [2:0] {
      ST_IDLE, ST_SEC, ST_MIN, ST_HOUR, ST_DATE, ST_MON, ST_YEAR, ST_ALARM
   } step_e;

   // stored byte -> plain binary value
   function automatic byte_t fmt_dec(input byte_t b, input logic bin);
      return bin ? b : ({4'd0, b[7:4]} * 8'd10 + {4'd0, b[3:0]});
   endfunction

   // plain binary value -> stored byte
   function automatic byte_t fmt_enc(input byte_t v, input logic bin);
      byte_t t, u;
      t = v / 8'd10;
      u = v % 8'd10;
      return bin ? v : {t[3:0], u[3:0]};
   endfunction
endpackage

// File: rtl/cal_wrap_inc.sv
module cal_wrap_inc
   import cal_pkg::*;
(
   input  byte_t cur,
   input  byte_t lo,
   input  byte_t hi,
   input  logic  bin,
   output byte_t nxt,
   output logic  wrap
);
   byte_t val;

   always_comb begin
      val  = fmt_dec(cur, bin);
      wrap = (val >= hi);
      nxt  = wrap ? fmt_enc(lo, bin) : fmt_enc(val + 8'd1, bin);
   end
endmodule

// File: rtl/cal_month_days.sv
module cal_month_days
   import cal_pkg::*;
(
   input  byte_t mon_val,
   input  byte_t yr_val,
   output byte_t days
);
   logic leap;

   always_comb begin
      leap = (yr_val[1:0] == 2'b00);
      unique case (mon_val)
         8'd2:                    days = leap ? 8'd29 : 8'd28;
         8'd4, 8'd6, 8'd9, 8'd11: days = 8'd30;
         default:                 days = 8'd31;
      endcase
   end
endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
   import cal_pkg::*;
#(
   parameter int LANES = 3
)(
   input  logic [LANES-1:0][7:0] now_b,
   input  logic [LANES-1:0][7:0] alm_b,
   output logic                  hit
);
   logic [LANES-1:0] lane_ok;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_ok[g] = (&alm_b[g][7:6]) || (alm_b[g] == now_b[g]);
   end

   assign hit = &lane_ok;
endmodule

// File: rtl/cal_update_engine.sv
module cal_update_engine
   import cal_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8,
   parameter bit DST_HW = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              bin_mode,
   input  logic              hr24_mode,
   input  logic              dst_en,
   input  logic              set_hold,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              alarm_pulse,
   output logic              done_pulse,
   output logic              busy
);
   localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(NUM_REGS - 1);

   if (DATA_W != 8) begin : g_bad_width
      $error("cal_update_engine: DATA_W must be 8");
   end
   if ((1 << ADDR_W) < NUM_REGS) begin : g_bad_addr
      $error("cal_update_engine: ADDR_W too narrow for the store");
   end

   byte_t store [NUM_REGS];
   step_e state;
   logic  carry;

   // shared wrap incrementer
   byte_t inc_cur, inc_lo, inc_hi, inc_nxt, mdays;
   logic  inc_wrap;

   cal_month_days i_mdays (
      .mon_val (fmt_dec(store[IDX_MON], bin_mode)),
      .yr_val  (fmt_dec(store[IDX_YR], bin_mode)),
      .days    (mdays)
   );

   always_comb begin
      inc_cur = store[IDX_SEC];
      inc_lo  = 8'd0;
      inc_hi  = 8'd59;
      unique case (state)
         ST_MIN:  inc_cur = store[IDX_MIN];
         ST_DATE: begin inc_cur = store[IDX_DATE]; inc_lo = 8'd1; inc_hi = mdays; end
         ST_MON:  begin inc_cur = store[IDX_MON];  inc_lo = 8'd1; inc_hi = 8'd12; end
         ST_YEAR: begin inc_cur = store[IDX_YR];   inc_hi = 8'd99; end
         default: ;
      endcase
   end

   cal_wrap_inc i_inc (
      .cur  (inc_cur),
      .lo   (inc_lo),
      .hi   (inc_hi),
      .bin  (bin_mode),
      .nxt  (inc_nxt),
      .wrap (inc_wrap)
   );

   // hour step with daylight-saving handling
   byte_t hr_val, nh, hr_nxt, enc_h, mon_v, dow_v, date_v, dow_nxt;
   logic  pm, npm, is_1am, hr_wrap, spring_hit, fall_hit, fall_done;

   always_comb begin
      hr_val = fmt_dec(hr24_mode ? store[IDX_HR] : {1'b0, store[IDX_HR][6:0]}, bin_mode);
      pm     = ~hr24_mode & store[IDX_HR][7];
      is_1am = (hr_val == 8'd1) && !pm;
      mon_v  = fmt_dec(store[IDX_MON], bin_mode);
      dow_v  = fmt_dec(store[IDX_DOW], bin_mode);
      date_v = fmt_dec(store[IDX_DATE], bin_mode);
   end

   if (DST_HW) begin : g_dst
      assign spring_hit = dst_en && is_1am && (mon_v == 8'd4) && (dow_v == 8'd1) && (date_v >= 8'd24);
      assign fall_hit   = dst_en && is_1am && !fall_done && (mon_v == 8'd10) && (dow_v == 8'd1) && (date_v >= 8'd25);
      always_ff @(posedge clk) begin
         if (!rst_n)
            fall_done <= 1'b0;
         else if (state == ST_HOUR && carry && !set_hold) begin
            if (fall_hit)     fall_done <= 1'b1;
            else if (is_1am)  fall_done <= 1'b0;
         end
      end
   end else begin : g_no_dst
      assign spring_hit = 1'b0;
      assign fall_hit   = 1'b0;
      assign fall_done  = 1'b0;
   end

   always_comb begin
      npm     = pm;
      hr_wrap = 1'b0;
      if (hr24_mode) begin
         if (hr_val >= 8'd23) begin nh = 8'd0; hr_wrap = 1'b1; end
         else nh = hr_val + 8'd1;
      end else if (hr_val >= 8'd12) begin
         nh = 8'd1;
      end else if (hr_val == 8'd11) begin
         nh = 8'd12; npm = ~pm; hr_wrap = pm;
      end else begin
         nh = hr_val + 8'd1;
      end
      if (spring_hit) begin nh = 8'd3; npm = 1'b0; end
      if (fall_hit)   begin nh = 8'd1; npm = 1'b0; end
      enc_h   = fmt_enc(nh, bin_mode);
      hr_nxt  = hr24_mode ? enc_h : {npm, enc_h[6:0]};
      dow_nxt = fmt_enc((dow_v >= 8'd7) ? 8'd1 : dow_v + 8'd1, bin_mode);
   end

   // engine write request for the current step
   logic  eng_we;
   int    eng_idx;
   byte_t eng_val;

   always_comb begin
      eng_we  = 1'b0;
      eng_idx = IDX_SEC;
      eng_val = inc_nxt;
      unique case (state)
         ST_SEC:  eng_we = 1'b1;
         ST_MIN:  begin eng_we = carry; eng_idx = IDX_MIN; end
         ST_HOUR: begin eng_we = carry; eng_idx = IDX_HR; eng_val = hr_nxt; end
         ST_DATE: begin eng_we = carry; eng_idx = IDX_DATE; end
         ST_MON:  begin eng_we = carry; eng_idx = IDX_MON; end
         ST_YEAR: begin eng_we = carry; eng_idx = IDX_YR; end
         default: ;
      endcase
      if (set_hold) eng_we = 1'b0;
   end

   logic alm_hit;

   cal_alarm_match #(.LANES(3)) i_alarm (
      .now_b ({store[IDX_HR], store[IDX_MIN], store[IDX_SEC]}),
      .alm_b ({store[IDX_AHR], store[IDX_AMIN], store[IDX_ASEC]}),
      .hit   (alm_hit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_REGS; i++) store[i] <= '0;
      end else begin
         if (eng_we) store[eng_idx] <= eng_val;
         if (eng_we && state == ST_DATE) store[IDX_DOW] <= dow_nxt;
         if (wr_en && wr_addr <= LAST_IDX) store[wr_addr] <= wr_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         carry       <= 1'b0;
         done_pulse  <= 1'b0;
         alarm_pulse <= 1'b0;
      end else begin
         done_pulse  <= 1'b0;
         alarm_pulse <= 1'b0;
         if (set_hold) begin
            state <= ST_IDLE;
            carry <= 1'b0;
         end else begin
            unique case (state)
               ST_IDLE:  if (tick) state <= ST_SEC;
               ST_SEC:   begin carry <= inc_wrap;          state <= ST_MIN;  end
               ST_MIN:   begin carry <= carry & inc_wrap;  state <= ST_HOUR; end
               ST_HOUR:  begin carry <= carry & hr_wrap;   state <= ST_DATE; end
               ST_DATE:  begin carry <= carry & inc_wrap;  state <= ST_MON;  end
               ST_MON:   begin carry <= carry & inc_wrap;  state <= ST_YEAR; end
               ST_YEAR:  begin carry <= 1'b0;              state <= ST_ALARM; end
               ST_ALARM: begin
                  done_pulse  <= 1'b1;
                  alarm_pulse <= alm_hit;
                  state       <= ST_IDLE;
               end
               default:  state <= ST_IDLE;
            endcase
         end
      end
   end

   assign busy    = (state != ST_IDLE);
   assign rd_data = (rd_addr <= LAST_IDX) ? store[rd_addr] : '0;
endmodule

// File: rtl/cal_update_engine_chk.sv
module cal_update_engine_chk (
   input logic clk,
   input logic rst_n,
   input logic tick,
   input logic set_hold,
   input logic busy,
   input logic done_pulse,
   input logic alarm_pulse
);
   assert_busy_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(tick) && !$past(set_hold));

   assert_done_after_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_pulse) |-> $past(busy) && !busy);

   assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse |=> !done_pulse);

   assert_alarm_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_pulse |-> done_pulse);

   assert_hold_stops_R10: assert property (@(posedge clk) disable iff (!rst_n)
      set_hold |=> !busy && !done_pulse);
endmodule

bind cal_update_engine cal_update_engine_chk i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tick        (tick),
   .set_hold    (set_hold),
   .busy        (busy),
   .done_pulse  (done_pulse),
   .alarm_pulse (alarm_pulse)
);

// File: tb/test_cal_update_engine.sv
module test_cal_update_engine;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0, bin_mode = 1'b0, hr24_mode = 1'b1, dst_en = 1'b0, set_hold = 1'b0;
   logic       wr_en = 1'b0;
   logic [3:0] wr_addr = '0, rd_addr = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       alarm_pulse, done_pulse, busy;
   int         nchk = 0, nfail = 0;

   always #2.5 clk = ~clk;

   cal_update_engine i_cal_update_engine (
      .clk(clk), .rst_n(rst_n), .tick(tick), .bin_mode(bin_mode), .hr24_mode(hr24_mode),
      .dst_en(dst_en), .set_hold(set_hold), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .alarm_pulse(alarm_pulse), .done_pulse(done_pulse), .busy(busy)
   );

   typedef struct packed {
      logic [7:0] rq;
      logic       bin, h24, dst;
      logic [7:0] s, m, h, dw, dt, mo, yr;
      logic [7:0] es, em, eh, edw, edt, emo, eyr;
   } vec_t;

   localparam int NV = 21;
   localparam vec_t VEC [NV] = '{
      '{8'd1, 1'b0,1'b1,1'b0, 8'h30,8'h20,8'h10,8'h03,8'h15,8'h06,8'h24, 8'h31,8'h20,8'h10,8'h03,8'h15,8'h06,8'h24}, // R1
      '{8'd2, 1'b0,1'b1,1'b0, 8'h09,8'h20,8'h10,8'h03,8'h15,8'h06,8'h24, 8'h10,8'h20,8'h10,8'h03,8'h15,8'h06,8'h24}, // R2 bcd
      '{8'd2, 1'b1,1'b1,1'b0, 8'h09,8'h14,8'h0A,8'h03,8'h0F,8'h06,8'h18, 8'h0A,8'h14,8'h0A,8'h03,8'h0F,8'h06,8'h18}, // R2 binary
      '{8'd1, 1'b0,1'b1,1'b0, 8'h59,8'h59,8'h10,8'h03,8'h15,8'h06,8'h24, 8'h00,8'h00,8'h11,8'h03,8'h15,8'h06,8'h24}, // R1 carry
      '{8'd3, 1'b0,1'b1,1'b0, 8'h59,8'h59,8'h23,8'h07,8'h15,8'h06,8'h24, 8'h00,8'h00,8'h00,8'h01,8'h16,8'h06,8'h24}, // R3 R6
      '{8'd4, 1'b0,1'b0,1'b0, 8'h59,8'h59,8'h11,8'h03,8'h15,8'h06,8'h24, 8'h00,8'h00,8'h92,8'h03,8'h15,8'h06,8'h24}, // R4 noon
      '{8'd4, 1'b0,1'b0,1'b0, 8'h59,8'h59,8'h92,8'h03,8'h15,8'h06,8'h24, 8'h00,8'h00,8'h81,8'h03,8'h15,8'h06,8'h24}, // R4 1 PM
      '{8'd4, 1'b0,1'b0,1'b0, 8'h59,8'h59,8'h91,8'h02,8'h10,8'h06,8'h24, 8'h00,8'h00,8'h12,8'h03,8'h11,8'h06,8'h24}, // R4 midnight
      '{8'd4, 1'b1,1'b0,1'b0, 8'h3B,8'h3B,8'h8B,8'h02,8'h0A,8'h06,8'h18, 8'h00,8'h00,8'h0C,8'h03,8'h0B,8'h06,8'h18}, // R4 binary
      '{8'd5, 1'b0,1'b1,1'b0, 8'h59,8'h59,8'h23,8'h05,8'h30,8'h04,8'h24, 8'h00,8'h00,8'h00,8'h06,8'h01,8'h05,8'h24}, // R5 30-day
      '{8'd5, 1'b0,1'b1,1'b0, 8'h59,8'h59,8'h23,8'h05,8'h28,8'h02,8'h23, 8'h00,8'h00,8'h00,8'h06,8'h01,8'h03,8'h23}, // R5 feb
      '{8'd5, 1'b0,1'b1,1'b0, 8'h59,8'h59,8'h23,8'h05,8'h28,8'h02,8'h24, 8'h00,8'h00,8'h00,8'h06,8'h29,8'h02,8'h24}, // R5 leap
      '{8'd5, 1'b0,1'b1,1'b0, 8'h59,8'h59,8'h23,8'h05,8'h29,8'h02,8'h24, 8'h00,8'h00,8'h00,8'h06,8'h01,8'h03,8'h24}, // R5 leap end
      '{8'd5, 1'b0,1'b1,1'b0, 8'h59,8'h59,8'h23,8'h07,8'h31,8'h12,8'h99, 8'h00,8'h00,8'h00,8'h01,8'h01,8'h01,8'h00}, // R5 R6 century
      '{8'd5, 1'b1,1'b1,1'b0, 8'h3B,8'h3B,8'h17,8'h04,8'h1F,8'h01,8'h05, 8'h00,8'h00,8'h00,8'h05,8'h01,8'h02,8'h05}, // R5 binary
      '{8'd5, 1'b0,1'b1,1'b0, 8'h59,8'h59,8'h23,8'h03,8'h30,8'h07,8'h24, 8'h00,8'h00,8'h00,8'h04,8'h31,8'h07,8'h24}, // R5 31-day
      '{8'd8, 1'b0,1'b1,1'b1, 8'h59,8'h59,8'h01,8'h01,8'h26,8'h04,8'h24, 8'h00,8'h00,8'h03,8'h01,8'h26,8'h04,8'h24}, // R8
      '{8'd8, 1'b0,1'b0,1'b1, 8'h59,8'h59,8'h01,8'h01,8'h30,8'h04,8'h24, 8'h00,8'h00,8'h03,8'h01,8'h30,8'h04,8'h24}, // R8 12h
      '{8'd8, 1'b0,1'b1,1'b1, 8'h59,8'h59,8'h01,8'h01,8'h17,8'h04,8'h24, 8'h00,8'h00,8'h02,8'h01,8'h17,8'h04,8'h24}, // R8 early
      '{8'd8, 1'b0,1'b1,1'b0, 8'h59,8'h59,8'h01,8'h01,8'h26,8'h04,8'h24, 8'h00,8'h00,8'h02,8'h01,8'h26,8'h04,8'h24}, // R8 off
      '{8'd4, 1'b0,1'b0,1'b0, 8'h59,8'h59,8'h12,8'h03,8'h15,8'h06,8'h24, 8'h00,8'h00,8'h01,8'h03,8'h15,8'h06,8'h24}  // R4 1 AM
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic load(input logic [7:0] s, m, h, dw, dt, mo, yr, as, am, ah);
      wr(4'd0, s); wr(4'd1, m); wr(4'd2, h); wr(4'd3, dw); wr(4'd4, dt);
      wr(4'd5, mo); wr(4'd6, yr); wr(4'd7, as); wr(4'd8, am); wr(4'd9, ah);
   endtask

   task automatic do_tick(output int nbusy, output bit seen_done, output bit seen_alarm);
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      nbusy = 0; seen_done = 1'b0; seen_alarm = 1'b0;
      for (int k = 0; k < 16 && !seen_done; k++) begin
         if (busy) nbusy++;
         if (done_pulse) begin seen_done = 1'b1; seen_alarm = alarm_pulse; end
         else @(negedge clk);
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      nfail++;
      $display("FAIL R11: watchdog expired, actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
   end

   initial begin : main
      logic [7:0] got;
      logic [7:0] exp_b [7];
      int  nb, ndone;
      bit  dn, al;
      string tag;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state
      chk("R12 reset busy", {7'd0, busy}, 8'd0);
      chk("R12 reset done", {7'd0, done_pulse}, 8'd0);
      chk("R12 reset alarm", {7'd0, alarm_pulse}, 8'd0);
      rd(4'd0, got); chk("R12 reset store", got, 8'h00);
      wr(4'd9, 8'h5A); rd(4'd9, got); chk("R12 write/read", got, 8'h5A);

      // vector table
      for (int v = 0; v < NV; v++) begin
         bin_mode = VEC[v].bin; hr24_mode = VEC[v].h24; dst_en = VEC[v].dst;
         load(VEC[v].s, VEC[v].m, VEC[v].h, VEC[v].dw, VEC[v].dt, VEC[v].mo, VEC[v].yr,
              8'h7F, 8'h7F, 8'h7F);
         do_tick(nb, dn, al);
         tag = $sformatf("R%0d vec%0d", VEC[v].rq, v);
         chk({"R11 busy len ", tag}, 8'(nb), 8'd7);
         chk({"R11 done ", tag}, {7'd0, dn}, 8'd1);
         exp_b = '{VEC[v].es, VEC[v].em, VEC[v].eh, VEC[v].edw, VEC[v].edt, VEC[v].emo, VEC[v].eyr};
         for (int b = 0; b < 7; b++) begin
            rd(4'(b), got);
            chk($sformatf("%s byte%0d", tag, b), got, exp_b[b]);
         end
      end

      // R7 alarm matching
      bin_mode = 1'b0; hr24_mode = 1'b1; dst_en = 1'b0;
      load(8'h30, 8'h20, 8'h10, 8'h03, 8'h15, 8'h06, 8'h24, 8'h31, 8'h20, 8'h10);
      do_tick(nb, dn, al); chk("R7 exact match", {7'd0, al}, 8'd1);
      wr(4'd7, 8'h33);
      do_tick(nb, dn, al); chk("R7 no match", {7'd0, al}, 8'd0);
      wr(4'd8, 8'hFF); wr(4'd9, 8'hC0);
      do_tick(nb, dn, al); chk("R7 wildcard hr/min", {7'd0, al}, 8'd1);
      wr(4'd7, 8'hC5);
      do_tick(nb, dn, al); chk("R7 all wildcard", {7'd0, al}, 8'd1);

      // R9 fall-back happens once
      dst_en = 1'b1;
      load(8'h59, 8'h59, 8'h01, 8'h01, 8'h28, 8'h10, 8'h24, 8'h7F, 8'h7F, 8'h7F);
      do_tick(nb, dn, al);
      rd(4'd2, got); chk("R9 first pass hour", got, 8'h01);
      rd(4'd1, got); chk("R9 first pass min", got, 8'h00);
      wr(4'd0, 8'h59); wr(4'd1, 8'h59);
      do_tick(nb, dn, al);
      rd(4'd2, got); chk("R9 second pass hour", got, 8'h02);
      dst_en = 1'b0;

      // R10 hold blocks ticks
      load(8'h40, 8'h20, 8'h10, 8'h03, 8'h15, 8'h06, 8'h24, 8'h7F, 8'h7F, 8'h7F);
      set_hold = 1'b1;
      do_tick(nb, dn, al);
      chk("R10 hold busy", 8'(nb), 8'd0);
      chk("R10 hold done", {7'd0, dn}, 8'd0);
      rd(4'd0, got); chk("R10 hold sec kept", got, 8'h40);
      set_hold = 1'b0;

      // R10 hold aborts an update
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      @(negedge clk); set_hold = 1'b1;
      @(negedge clk); @(negedge clk); set_hold = 1'b0;
      ndone = 0;
      for (int k = 0; k < 12; k++) begin
         if (done_pulse) ndone++;
         @(negedge clk);
      end
      chk("R10 abort no done", 8'(ndone), 8'd0);
      chk("R10 abort idle", {7'd0, busy}, 8'd0);

      // R11 tick while busy ignored
      load(8'h10, 8'h20, 8'h10, 8'h03, 8'h15, 8'h06, 8'h24, 8'h7F, 8'h7F, 8'h7F);
      @(negedge clk); tick = 1'b1;
      repeat (3) @(negedge clk);
      tick = 1'b0;
      ndone = 0;
      for (int k = 0; k < 20; k++) begin
         if (done_pulse) ndone++;
         @(negedge clk);
      end
      chk("R11 one update per burst", 8'(ndone), 8'd1);
      rd(4'd0, got); chk("R11 sec advanced once", got, 8'h11);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
   end
endmodule